// File: doc/BRIEF.md
# I2C Master Byte Engine with Arbitration Watch

This block moves one byte at a time across a two-wire open-drain serial bus while acting as bus master. In transmit mode it presents the byte on the data line, most significant bit first, and reads back the receiver's acknowledge on a ninth clock. In receive mode it collects a byte from the data line and answers it on the ninth clock, either holding the line low (ACK) or leaving it released (NACK). The engine does not make the serial clock itself. A separate clock generator gives it two one-cycle strobes: one in the low phase of each clock, when the data line may change, and one in the high phase, when the line is sampled.

While it transmits, the engine compares every released (logic 1) bit with the level it reads back. If another master pulls the line low, arbitration is lost. The engine then becomes a slave receiver at once and stops driving. It still asks for clock pulses until the byte in progress and its ninth clock are finished, and it asks for none after that. In receive mode the only bit on which arbitration can be lost is a returned NACK. After every byte an interrupt flag is raised. It also tells the clock generator to hold the clock low, and it stays set until software clears it. Software also clears a sticky arbitration-lost status bit.

Top module: `i2cByteEngine`

## Requirements
- R1: After reset, `mode` is 0 (idle), `irqFlag`, `arbLost`, `sclReq` and `sdaOe` are 0. The mode encoding is 1 = master transmitter, 2 = master receiver, 3 = slave receiver.
- R2: In master-transmitter mode, the k-th low strobe (k = 0..7) of a byte sets `sdaOe` to the inverse of bit 7−k of the byte loaded by `startTx`. The ninth low strobe releases the line (`sdaOe` = 0).
- R3: In master-receiver mode, the first eight low strobes leave `sdaOe` at 0. The level sampled on the k-th high strobe becomes bit 7−k of `rxData`. The ninth low strobe sets `sdaOe` to `rxAckEn` as captured at `startRx`.
- R4: On the ninth high strobe, `ackRcvd` takes the inverse of the sampled line (1 = ACK, line low) and `rxData` is updated. On the same edge `irqFlag` rises and `sclReq` falls. `irqFlag` stays set until `clrIrq` is pulsed.
- R5: A start command is ignored while a byte is in progress or while `irqFlag` is set. `startTx` wins if both starts are pulsed together.
- R6: In master-transmitter mode, a high strobe on one of the eight data bits that finds the line low while the engine released it sets `arbLost` and switches `mode` to 3 on that edge. From then on `sdaOe` stays 0.
- R7: After an arbitration loss, `sclReq` stays 1 through the rest of the byte's nine clocks and then falls. While `arbLost` is set, no start command is accepted, so no clock is requested for a further byte.
- R8: In master-receiver mode, a low line on a data bit, or on an ACK the engine drives itself, never causes a loss. A low line seen while returning a NACK on the ninth bit does cause one.
- R9: `sdaOe` changes only on the clock edge that registers a low strobe. It is steady across high strobes.
- R10: `arbLost` is sticky and is cleared only by a `clrArb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startTx | input | 1 | Pulse: begin transmitting `txData` |
| startRx | input | 1 | Pulse: begin receiving a byte |
| txData | input | DATA_BITS | Byte to transmit, taken at `startTx` |
| rxAckEn | input | 1 | At `startRx`: 1 = answer with ACK, 0 = NACK |
| clrIrq | input | 1 | Pulse: clear the interrupt flag |
| clrArb | input | 1 | Pulse: clear the arbitration-lost bit |
| sclLowStrobe | input | 1 | From clock generator: SCL low phase, data may change |
| sclHighStrobe | input | 1 | From clock generator: SCL high phase, sample data |
| sdaIn | input | 1 | Sampled level of the data line |
| sdaOe | output | 1 | 1 = pull the data line low |
| sclReq | output | 1 | 1 = clock generator should keep producing pulses |
| irqFlag | output | 1 | Byte done; also a request to stretch SCL low |
| mode | output | 2 | 0 idle, 1 master transmitter, 2 master receiver, 3 slave receiver |
| arbLost | output | 1 | Sticky arbitration-lost status |
| ackRcvd | output | 1 | 1 = ACK seen on the last ninth bit |
| rxData | output | DATA_BITS | Byte shifted in during the last transfer |

## Verification
The bench builds the engine with its default byte width of eight data bits, so one transfer is nine strobe pairs. Every bit position, including the ninth, can then be hit with a competing low driver from the bus model. A bench-side reference computes the expected line drive, the bit on which arbitration is lost, the received byte and the acknowledge for each random transfer. Directed cases cover a loss on the NACK versus harmless lows on data and ACK bits, and starts refused while the flag or the loss bit is set.

// File: rtl/i2cByteEnginePkg.sv
package i2cByteEnginePkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_MTX  = 2'd1,
    MODE_MRX  = 2'd2,
    MODE_SRX  = 2'd3
  } engineMode_e;

  typedef enum logic [1:0] {
    DRV_HOLD    = 2'd0,
    DRV_RELEASE = 2'd1,
    DRV_DATA    = 2'd2,
    DRV_LOW     = 2'd3
  } driveSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    driveSel_e drive;
    logic      sampleData;
    logic      latchAck;
  } dpCtl_t;

endpackage

// File: rtl/i2cByteDatapath.sv
module i2cByteDatapath
  import i2cByteEnginePkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  output logic                 lineLow,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 ackRcvd
);

  logic [DATA_BITS-1:0] shiftReg;

  // shift register: loaded at start, MSB leaves first, samples enter at LSB
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.load) begin
      shiftReg <= txData;
    end else if (ctl.sampleData) begin
      shiftReg <= {shiftReg[DATA_BITS-2:0], sdaIn};
    end
  end

  // open-drain enable, updated only when control selects a drive action
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
    end else begin
      case (ctl.drive)
        DRV_RELEASE: sdaOe <= 1'b0;
        DRV_DATA:    sdaOe <= ~shiftReg[DATA_BITS-1];
        DRV_LOW:     sdaOe <= 1'b1;
        default:     sdaOe <= sdaOe;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData  <= '0;
      ackRcvd <= 1'b0;
    end else if (ctl.latchAck) begin
      rxData  <= shiftReg;
      ackRcvd <= ~sdaIn;
    end
  end

  // released by us yet low on the wire: someone else is driving
  assign lineLow = ~sdaOe & ~sdaIn;

  AST_NO_LOAD_WHILE_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.sampleData)) else $error("load and sample together"); // R5

endmodule

// File: rtl/i2cByteControl.sv
module i2cByteControl
  import i2cByteEnginePkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startTx,
  input  logic        startRx,
  input  logic        rxAckEn,
  input  logic        clrIrq,
  input  logic        clrArb,
  input  logic        sclLowStrobe,
  input  logic        sclHighStrobe,
  input  logic        lineLow,
  output dpCtl_t      ctl,
  output logic        sclReq,
  output logic        irqFlag,
  output logic [1:0]  mode,
  output logic        arbLost
);

  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_BITS);

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             ackEnReg;
  engineMode_e      modeReg;

  logic canStart, goTx, goRx, atAck, lostNow, doneNow;

  always_comb begin
    canStart = !busy && !irqFlag && !arbLost;
    goTx     = canStart && startTx;
    goRx     = canStart && startRx && !startTx;
    atAck    = (bitCnt == ACK_IDX);
    lostNow  = busy && sclHighStrobe && lineLow &&
               (((modeReg == MODE_MTX) && !atAck) ||
                ((modeReg == MODE_MRX) && atAck));
    doneNow  = busy && sclHighStrobe && atAck;
  end

  // datapath strobes
  always_comb begin
    ctl            = '0;
    ctl.drive      = DRV_HOLD;
    ctl.load       = goTx || goRx;
    ctl.sampleData = busy && sclHighStrobe && !atAck;
    ctl.latchAck   = doneNow;
    if (sclLowStrobe) begin
      if (!busy || modeReg == MODE_SRX) begin
        ctl.drive = DRV_RELEASE;
      end else if (!atAck) begin
        ctl.drive = (modeReg == MODE_MTX) ? DRV_DATA : DRV_RELEASE;
      end else begin
        ctl.drive = (modeReg == MODE_MRX && ackEnReg) ? DRV_LOW : DRV_RELEASE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitCnt   <= '0;
      ackEnReg <= 1'b0;
      modeReg  <= MODE_IDLE;
    end else begin
      if (goTx || goRx) begin
        busy     <= 1'b1;
        bitCnt   <= '0;
        ackEnReg <= goRx && rxAckEn;
        modeReg  <= goTx ? MODE_MTX : MODE_MRX;
      end else begin
        if (lostNow) modeReg <= MODE_SRX;
        if (doneNow) begin
          busy <= 1'b0;
        end else if (busy && sclHighStrobe) begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      arbLost <= 1'b0;
    end else begin
      if (doneNow)     irqFlag <= 1'b1;
      else if (clrIrq) irqFlag <= 1'b0;
      if (lostNow)     arbLost <= 1'b1;
      else if (clrArb) arbLost <= 1'b0;
    end
  end

  assign sclReq = busy;
  assign mode   = modeReg;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= ACK_IDX) else $error("bit counter out of range"); // R2
  AST_LOSS_TO_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> (mode == MODE_SRX)) else $error("loss without slave mode"); // R6
  AST_IRQ_ENDS_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !sclReq) else $error("clock still requested at irq"); // R4
  AST_NO_CLOCK_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !sclReq) |=> !sclReq) else $error("clock restarted after loss"); // R7
  AST_MRX_LOSS_AT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(arbLost) && $past(modeReg == MODE_MRX)) |-> $past(bitCnt == ACK_IDX))
    else $error("receive loss off the ninth bit"); // R8

endmodule

// File: rtl/i2cByteEngine.sv
module i2cByteEngine
  import i2cByteEnginePkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startTx,
  input  logic                 startRx,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 rxAckEn,
  input  logic                 clrIrq,
  input  logic                 clrArb,
  input  logic                 sclLowStrobe,
  input  logic                 sclHighStrobe,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  output logic                 sclReq,
  output logic                 irqFlag,
  output logic [1:0]           mode,
  output logic                 arbLost,
  output logic                 ackRcvd,
  output logic [DATA_BITS-1:0] rxData
);

  dpCtl_t ctl;
  logic   lineLow;

  i2cByteControl #(.DATA_BITS(DATA_BITS)) i_control (
    .clk(clk), .rstN(rstN), .startTx(startTx), .startRx(startRx),
    .rxAckEn(rxAckEn), .clrIrq(clrIrq), .clrArb(clrArb),
    .sclLowStrobe(sclLowStrobe), .sclHighStrobe(sclHighStrobe),
    .lineLow(lineLow), .ctl(ctl), .sclReq(sclReq), .irqFlag(irqFlag),
    .mode(mode), .arbLost(arbLost)
  );

  i2cByteDatapath #(.DATA_BITS(DATA_BITS)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txData(txData), .sdaIn(sdaIn),
    .sdaOe(sdaOe), .lineLow(lineLow), .rxData(rxData), .ackRcvd(ackRcvd)
  );

  AST_SDA_ON_LOW_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaOe) |-> $past(sclLowStrobe)) else $error("SDA moved outside low phase"); // R9
  AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SRX) |-> !sdaOe) else $error("slave receiver drives SDA"); // R6

endmodule

// File: tb/test_i2cByteEngine.sv
module test_i2cByteEngine;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic startTx, startRx, rxAckEn, clrIrq, clrArb;
  logic sclLowStrobe, sclHighStrobe;
  logic [W-1:0] txData;
  logic otherLow;
  logic sdaIn, sdaOe, sclReq, irqFlag, arbLost, ackRcvd;
  logic [1:0] mode;
  logic [W-1:0] rxData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND bus: low if either side pulls
  assign sdaIn = ~(sdaOe | otherLow);

  i2cByteEngine #(.DATA_BITS(W)) i_i2cByteEngine (
    .clk(clk), .rstN(rstN), .startTx(startTx), .startRx(startRx),
    .txData(txData), .rxAckEn(rxAckEn), .clrIrq(clrIrq), .clrArb(clrArb),
    .sclLowStrobe(sclLowStrobe), .sclHighStrobe(sclHighStrobe), .sdaIn(sdaIn),
    .sdaOe(sdaOe), .sclReq(sclReq), .irqFlag(irqFlag), .mode(mode),
    .arbLost(arbLost), .ackRcvd(ackRcvd), .rxData(rxData)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic lowPhase();
    @(negedge clk) sclLowStrobe = 1'b1;
    @(negedge clk) sclLowStrobe = 1'b0;
  endtask

  task automatic highPhase();
    @(negedge clk) sclHighStrobe = 1'b1;
    @(negedge clk) sclHighStrobe = 1'b0;
  endtask

  task automatic pulseStart(bit isTx, logic [W-1:0] data, bit ackEn);
    @(negedge clk);
    startTx = isTx; startRx = !isTx; txData = data; rxAckEn = ackEn;
    @(negedge clk);
    startTx = 1'b0; startRx = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk) clrIrq = 1'b1; clrArb = 1'b1;
    @(negedge clk) clrIrq = 1'b0; clrArb = 1'b0;
    check("R4", "irq cleared", 32'(irqFlag), 32'd0);
    check("R10", "arbLost cleared", 32'(arbLost), 32'd0);
  endtask

  // expected drive for bit k under the requirement model
  function automatic bit expDrive(bit isTx, logic [W-1:0] data, bit ackEn, bit lost, int k);
    if (lost) return 1'b0;
    if (k < W) return isTx ? !data[W-1-k] : 1'b0;
    return isTx ? 1'b0 : ackEn;
  endfunction

  // one full transfer; pull[k] = competitor holds the line low on bit k
  task automatic runByte(bit isTx, logic [W-1:0] data, bit ackEn, logic [W:0] pull);
    bit lost = 1'b0;
    bit bus, drv;
    logic [W-1:0] rxExp = '0;
    bit ackExp = 1'b0;
    pulseStart(isTx, data, ackEn);
    check("R5", "start accepted", 32'(sclReq), 32'd1);
    check("R1", "mode after start", 32'(mode), isTx ? 32'd1 : 32'd2);
    for (int k = 0; k <= W; k++) begin
      lowPhase();
      drv = expDrive(isTx, data, ackEn, lost, k);
      check(lost ? "R6" : (isTx ? "R2" : "R3"), $sformatf("drive bit %0d", k), 32'(sdaOe), 32'(drv));
      otherLow = pull[k];
      bus = !(drv | pull[k]);
      if (!lost && !drv && !bus && ((isTx && k < W) || (!isTx && k == W))) lost = 1'b1;
      if (k < W) rxExp[W-1-k] = bus;
      else ackExp = !bus;
      highPhase();
      otherLow = 1'b0;
      check("R9", "sda steady over high strobe", 32'(sdaOe), 32'(drv));
      check(isTx ? "R6" : "R8", "arbLost", 32'(arbLost), 32'(lost));
      if (lost) check("R6", "slave mode", 32'(mode), 32'd3);
      if (k < W) check("R7", "clock kept in byte", 32'(sclReq), 32'd1);
    end
    check("R4", "irq set", 32'(irqFlag), 32'd1);
    check("R4", "clock dropped", 32'(sclReq), 32'd0);
    check("R4", "ack status", 32'(ackRcvd), 32'(ackExp));
    check("R3", "rxData", 32'(rxData), 32'(rxExp));
    check("R1", "final mode", 32'(mode), lost ? 32'd3 : (isTx ? 32'd1 : 32'd2));
    lowPhase();
    check("R9", "released after byte", 32'(sdaOe), 32'd0);
  endtask

  initial begin
    rstN = 1'b0; startTx = 0; startRx = 0; rxAckEn = 0; clrIrq = 0; clrArb = 0;
    sclLowStrobe = 0; sclHighStrobe = 0; txData = '0; otherLow = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset mode", 32'(mode), 32'd0);
    check("R1", "reset irq", 32'(irqFlag), 32'd0);
    check("R1", "reset arb", 32'(arbLost), 32'd0);
    check("R1", "reset sclReq", 32'(sclReq), 32'd0);
    check("R1", "reset sdaOe", 32'(sdaOe), 32'd0);

    // directed: clean transmit, ACK returned by receiver
    runByte(1'b1, 8'hA5, 1'b0, 9'b1_0000_0000);
    // R5: start ignored while irq set
    pulseStart(1'b1, 8'h3C, 1'b0);
    check("R5", "start ignored with irq", 32'(sclReq), 32'd0);
    check("R5", "mode kept with irq", 32'(mode), 32'd1);
    clearAll();

    // directed transmit loss on bit 2 (0xFF sends 1s)
    runByte(1'b1, 8'hFF, 1'b0, 9'b0_0000_0100);
    @(negedge clk) clrIrq = 1'b1;
    @(negedge clk) clrIrq = 1'b0;
    pulseStart(1'b1, 8'h55, 1'b0);
    check("R7", "start ignored while arbLost", 32'(sclReq), 32'd0);
    check("R10", "arbLost sticky", 32'(arbLost), 32'd1);
    check("R7", "still slave", 32'(mode), 32'd3);
    clearAll();

    // R8 directed: data lows harmless, own ACK harmless, NACK overruled loses
    runByte(1'b0, 8'h00, 1'b1, 9'b1_1111_1111);
    clearAll();
    runByte(1'b0, 8'h00, 1'b0, 9'b0_1010_0101);
    clearAll();
    runByte(1'b0, 8'h00, 1'b0, 9'b1_0011_0000);
    check("R8", "loss on NACK", 32'(arbLost), 32'd1);
    clearAll();

    // random transfers
    for (int n = 0; n < 60; n++) begin
      bit isTx = $urandom_range(1);
      logic [W-1:0] d = W'($urandom);
      bit ackEn = $urandom_range(1);
      logic [W:0] pull;
      if (isTx) begin
        for (int b = 0; b < W; b++) pull[b] = ($urandom_range(9) == 0);
        pull[W] = $urandom_range(1);
      end else begin
        pull[W-1:0] = W'($urandom);
        pull[W] = ($urandom_range(2) == 0);
      end
      runByte(isTx, d, ackEn, pull);
      clearAll();
    end

    summary();
  end

endmodule